// File: doc/BRIEF.md
# Transmit Timestamp Tracking Buffer

This block keeps the timing record of one outgoing event packet on the transmit side. Filling it takes two steps. First, when an event packet is detected, or when software forces a capture, the block latches the packet's 16-bit sequence ID and marks the entry as pending. Later, when the MAC reports that the frame has left, the block latches the 64-bit egress timestamp. In the same cycle it drops the pending mark and marks the entry valid.

Software sees a 19-bit status word and two read-only 32-bit timestamp words. The status word carries the sequence ID, the valid flag, the pending flag, and a flag that records whether software or hardware asked for the capture. The buffer holds one entry. It stays occupied, and refuses new captures, until software writes 1 to the valid bit, which empties it completely.

Top module: `tx_ts_track`

## Requirements
- R1: After reset the status word, the low timestamp word and the high timestamp word are all zero.
- R2: A capture strobe while the buffer is empty shows up after the next clock edge. The strobe's sequence ID appears in status bits 15:0, pending bit 17 is 1, valid bit 16 is 0, and bit 18 equals the strobe's source input (1 = software request, 0 = hardware detection).
- R3: An egress strobe while bit 17 is set does three things at the same clock edge: it stores the 64-bit timestamp, clears bit 17 and sets bit 16. Bits 15:0 and 18 are kept.
- R4: The low timestamp word holds timestamp bits 31:0 and the high word holds bits 63:32.
- R5: A capture strobe while bit 16 or bit 17 is set has no effect on the status word or on the timestamp words.
- R6: An egress strobe while bit 17 is clear has no effect on the status word or on the timestamp words.
- R7: A status write with the value of bit 16 equal to 1 zeroes the whole status word (bits 15:0, 16, 17 and 18) and both timestamp words after the next edge. This abandons any pending capture. A status write with bit 16 equal to 0 has no effect.
- R8: A clearing write in the same cycle as a capture strobe or an egress strobe takes priority, so the buffer ends up empty.
- R9: Bits 16 and 17 are never set at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_stb | input | 1 | Capture request for a transmit event packet |
| cap_sw | input | 1 | Source of the capture request: 1 = software, 0 = hardware |
| cap_seq | input | 16 | Sequence ID presented with cap_stb |
| egr_stb | input | 1 | MAC report that the frame has left |
| egr_ts | input | 64 | Egress timestamp presented with egr_stb |
| wr_en | input | 1 | Write strobe for the status word |
| wr_valid_bit | input | 1 | Value written to status bit 16 (1 empties the buffer) |
| stat_word | output | 19 | Status word {src, pending, valid, seq} |
| ts_lo_word | output | 32 | Timestamp bits 31:0 |
| ts_hi_word | output | 32 | Timestamp bits 63:32 |

## Verification
Some internal faults cannot stay hidden. If the pending flag is stuck or lost, the next egress strobe either fails to set the valid bit or sets it without a capture, and the status word shows this one edge later. A clear with the wrong priority, or a clear that misses a field, leaves a stale sequence ID, source flag or timestamp visible right after the clearing write. A capture that slips past the occupancy guard overwrites bits 15:0 one cycle after the rejected strobe. For this reason the bench compares every output after every stimulus cycle rather than only at the end of a sequence.

// File: rtl/tstb_pkg.sv
package tstb_pkg;
    localparam int SEQ_W  = 16;
    localparam int TS_W   = 64;
    localparam int WORD_W = 32;
    localparam int NWORDS = TS_W / WORD_W;
    localparam int STAT_W = SEQ_W + 3;

    // Field order is what software decodes: seq in 15:0, valid 16, pending 17, source 18.
    typedef struct packed {
        logic             src_sw;
        logic             pending;
        logic             valid;
        logic [SEQ_W-1:0] seq;
    } tstb_stat_t;

    localparam tstb_stat_t STAT_EMPTY = '{src_sw: 1'b0, pending: 1'b0, valid: 1'b0, seq: '0};

    function automatic logic [STAT_W-1:0] stat_to_word(input tstb_stat_t s);
        return s;
    endfunction

    function automatic logic stat_busy(input tstb_stat_t s);
        return s.valid | s.pending;
    endfunction
endpackage

// File: rtl/tstb_ctrl.sv
module tstb_ctrl
    import tstb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             cap_stb,
    input  logic             cap_sw,
    input  logic [SEQ_W-1:0] cap_seq,
    input  logic             egr_stb,
    output tstb_stat_t       stat,
    output logic             ts_load
);
    tstb_stat_t stat_q, stat_d;
    logic       take_cap;

    assign take_cap = cap_stb && !stat_busy(stat_q) && !clr;
    assign ts_load  = egr_stb && stat_q.pending && !clr;

    always_comb begin
        stat_d = stat_q;
        if (clr) begin
            stat_d = STAT_EMPTY;
        end else if (take_cap) begin
            stat_d.seq     = cap_seq;
            stat_d.src_sw  = cap_sw;
            stat_d.pending = 1'b1;
            stat_d.valid   = 1'b0;
        end else if (ts_load) begin
            stat_d.pending = 1'b0;
            stat_d.valid   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= STAT_EMPTY;
        else     stat_q <= stat_d;
    end

    assign stat = stat_q;

    // R9
    excl_flags_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stat_q.valid, stat_q.pending}));
    // R2
    cap_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_stb && !stat_q.valid && !stat_q.pending && !clr)
        |=> (stat_q.pending && stat_q.seq == $past(cap_seq) && stat_q.src_sw == $past(cap_sw)));
    // R5
    cap_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_stb && (stat_q.valid || stat_q.pending) && !clr && !egr_stb) |=> $stable(stat_q));
    // R3
    egr_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (egr_stb && stat_q.pending && !clr)
        |=> (stat_q.valid && !stat_q.pending && $stable(stat_q.seq) && $stable(stat_q.src_sw)));
    // R7
    clr_all_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (stat_q == STAT_EMPTY));
endmodule

// File: rtl/tstb_tsreg.sv
module tstb_tsreg
    import tstb_pkg::*;
#(
    parameter int P_TS_W   = TS_W,
    parameter int P_WORD_W = WORD_W,
    localparam int NW      = P_TS_W / P_WORD_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         load,
    input  logic [P_TS_W-1:0]            ts_in,
    output logic [NW-1:0][P_WORD_W-1:0]  words
);
    for (genvar w = 0; w < NW; w++) begin : g_word
        logic [P_WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst || clr) word_q <= '0;
            else if (load)  word_q <= ts_in[w*P_WORD_W +: P_WORD_W];
        end
        assign words[w] = word_q;
    end

    // R3
    ts_load_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !clr) |=> (words == $past(ts_in)));
    // R6
    ts_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !clr) |=> $stable(words));
    // R7
    ts_clr_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (words == '0));
endmodule

// File: rtl/tx_ts_track.sv
module tx_ts_track
    import tstb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cap_stb,
    input  logic                cap_sw,
    input  logic [SEQ_W-1:0]    cap_seq,
    input  logic                egr_stb,
    input  logic [TS_W-1:0]     egr_ts,
    input  logic                wr_en,
    input  logic                wr_valid_bit,
    output logic [STAT_W-1:0]   stat_word,
    output logic [WORD_W-1:0]   ts_lo_word,
    output logic [WORD_W-1:0]   ts_hi_word
);
    logic                          clr;
    logic                          ts_load;
    tstb_stat_t                    stat;
    logic [NWORDS-1:0][WORD_W-1:0] words;

    assign clr = wr_en && wr_valid_bit;

    tstb_ctrl u_ctrl (
        .clk(clk), .rst(rst), .clr(clr),
        .cap_stb(cap_stb), .cap_sw(cap_sw), .cap_seq(cap_seq),
        .egr_stb(egr_stb), .stat(stat), .ts_load(ts_load)
    );

    tstb_tsreg #(.P_TS_W(TS_W), .P_WORD_W(WORD_W)) u_ts (
        .clk(clk), .rst(rst), .clr(clr), .load(ts_load),
        .ts_in(egr_ts), .words(words)
    );

    assign stat_word  = stat_to_word(stat);
    assign ts_lo_word = words[0];
    assign ts_hi_word = words[NWORDS-1];

    // R4
    word_map_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_word[16] && $rose(stat_word[16])) |-> ({ts_hi_word, ts_lo_word} == $past(egr_ts)));
endmodule

// File: tb/tb_tx_ts_track.sv
`timescale 1ns/1ps
module tb_tx_ts_track;
    logic        clk = 0;
    logic        rst;
    logic        cap_stb, cap_sw, egr_stb, wr_en, wr_valid_bit;
    logic [15:0] cap_seq;
    logic [63:0] egr_ts;
    logic [18:0] stat_word;
    logic [31:0] ts_lo_word, ts_hi_word;

    always #2.5 clk = ~clk;

    tx_ts_track dut (
        .clk(clk), .rst(rst), .cap_stb(cap_stb), .cap_sw(cap_sw), .cap_seq(cap_seq),
        .egr_stb(egr_stb), .egr_ts(egr_ts), .wr_en(wr_en), .wr_valid_bit(wr_valid_bit),
        .stat_word(stat_word), .ts_lo_word(ts_lo_word), .ts_hi_word(ts_hi_word)
    );

    typedef struct {
        logic [18:0] st;
        logic [63:0] ts;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // reference state kept from the requirements
    logic [15:0] m_seq;
    logic        m_val, m_pend, m_sw;
    logic [63:0] m_ts;

    function automatic logic [18:0] m_word();
        return {m_sw, m_pend, m_val, m_seq};
    endfunction

    task automatic push(string tag);
        exp_t e;
        e.st = m_word(); e.ts = m_ts; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // one stimulus cycle, reference update, expectation queued
    task automatic step(input logic c, input logic csw, input logic [15:0] cs,
                        input logic e, input logic [63:0] et,
                        input logic w, input logic wv, input string tag);
        @(negedge clk);
        cap_stb = c; cap_sw = csw; cap_seq = cs;
        egr_stb = e; egr_ts = et; wr_en = w; wr_valid_bit = wv;
        @(posedge clk);
        if (w && wv) begin
            m_seq = 0; m_val = 0; m_pend = 0; m_sw = 0; m_ts = 0;
        end else if (c && !m_val && !m_pend) begin
            m_seq = cs; m_sw = csw; m_pend = 1; m_val = 0;
        end else if (e && m_pend) begin
            m_ts = et; m_pend = 0; m_val = 1;
        end
        push(tag);
    endtask

    // monitor: pop and compare away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (stat_word !== e.st || {ts_hi_word, ts_lo_word} !== e.ts) begin
                n_fail++;
                $display("FAIL %s: stat=%h ts=%h expected stat=%h ts=%h",
                         e.tag, stat_word, {ts_hi_word, ts_lo_word}, e.st, e.ts);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; cap_stb = 0; cap_sw = 0; cap_seq = 0; egr_stb = 0; egr_ts = 0;
        wr_en = 0; wr_valid_bit = 0;
        m_seq = 0; m_val = 0; m_pend = 0; m_sw = 0; m_ts = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        @(posedge clk); push("R1 reset state");

        step(1, 0, 16'hA5C3, 0, 0, 0, 0, "R2 hw capture");
        step(1, 1, 16'h1111, 0, 0, 0, 0, "R5 capture while pending");
        step(0, 0, 0, 1, 64'h0123_4567_89AB_CDEF, 0, 0, "R3 egress while pending");
        step(0, 0, 0, 0, 0, 0, 0, "R4 word split held");
        step(1, 1, 16'h2222, 0, 0, 0, 0, "R5 capture while valid");
        step(0, 0, 0, 1, 64'hFFFF_0000_FFFF_0000, 0, 0, "R6 egress while valid");
        step(0, 0, 0, 0, 0, 1, 0, "R7 write bit16=0 no effect");
        step(0, 0, 0, 0, 0, 1, 1, "R7 clear valid entry");
        step(0, 0, 0, 1, 64'hDEAD_BEEF_0000_0001, 0, 0, "R6 egress while empty");
        step(1, 1, 16'hFFFF, 0, 0, 0, 0, "R2 sw capture");
        step(0, 0, 0, 0, 0, 1, 1, "R7 clear abandons pending");
        step(1, 0, 16'h0001, 0, 0, 1, 1, "R8 clear beats capture");
        step(1, 1, 16'h7E57, 0, 0, 0, 0, "R2 capture after clear");
        step(0, 0, 0, 1, 64'h5555_AAAA_1234_5678, 1, 1, "R8 clear beats egress");
        step(1, 0, 16'h0F0F, 0, 0, 0, 0, "R2 hw capture again");
        step(0, 0, 0, 1, 64'h8000_0000_0000_0001, 0, 0, "R3 egress, bits kept, R9");
        step(0, 0, 0, 1, 64'h1, 0, 0, "R6 second egress ignored");
        step(0, 0, 0, 0, 0, 0, 0, "R4 words after second egress");
        for (int i = 0; i < 4; i++) begin
            step(0, 0, 0, 0, 0, 1, 1, "R7 clear in loop");
            step(1, i[0], 16'(i * 16'h1357), 0, 0, 0, 0, "R2 loop capture");
            step(0, 0, 0, 1, {32'(i + 7), 32'(~i)}, 0, 0, "R3 loop egress");
        end

        @(negedge clk); @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule